// File: doc/BRIEF.md
# Bitplane Pixel Color Index Decoder

This block turns the bitplane bits of one pixel into the value that drives the color stage. Each pixel clock it takes up to eight plane bits. Under the control of a held mode register, it produces one of two results: a color-table index with a half-intensity flag, or a raw 8-bit pixel value that skips the color table. The mode register sets how many planes are live. It also selects single or dual playfield, the half-brite reduction, the hold-and-modify flag and the color-table bypass.

The index leaves a register one cycle after the plane bits are sampled. An external palette memory answers that index in the same cycle. One cycle later the block returns the palette color, halved per channel when the half-intensity flag was set. A small secondary register holds five extended control bits. Software may write them at any time, but they only reach the `ext_eff` output while the extended-enable bit of the mode register is set. Hold-and-modify colour arithmetic is not done here; the mode is only reported on `ham_active`.

Top module: `bpl_pixel_decode`

## Requirements
- R1: The mode register holds the plane count in bits [3:0], dual playfield in bit 4, hold-and-modify in bit 5, bypass in bit 6, extended enable in bit 7, interlace in bit 8, light pen in bit 9 and external resync in bit 10. It is cleared by reset and is written on a clock edge with `ctl_we` high. A count above 8 acts as 8.
- R2: A plane input whose number (0-based) is at or above the live plane count is treated as zero in every mode.
- R3: Half-brite applies only when the count is exactly 6 and both hold-and-modify and dual playfield are 0.
- R4: In half-brite mode, `color_idx` is planes 0..4 (upper bits zero) and `half_flag` equals plane 5. Outside half-brite, `half_flag` is 0.
- R5: Each channel of `rgb_out` (three 4-bit channels) equals the palette color for `color_idx`, one cycle later. When `half_flag` was set, each channel is first shifted right by one.
- R6: In dual playfield, planes 0,2,4,6 form playfield A and planes 1,3,5,7 form playfield B. A nonzero A value is the index. Otherwise a nonzero B value plus 8 is the index, and 0 when both are zero.
- R7: With bypass set, `raw_pix` carries the ordered and prioritized plane value (the R6 result in dual playfield, the masked planes otherwise), with `color_idx` 0 and `half_flag` 0. Without bypass, `raw_pix` is 0.
- R8: `ham_active` follows the hold-and-modify bit with the same latency as `color_idx`. In single playfield with hold-and-modify set, the index is the masked planes.
- R9: The extended register is written through `ext_we` at any time. `ext_eff` equals its content while extended enable is 1 and is 0 otherwise.
- R10: Reset clears interlace, light pen and external resync, the extended register and all pixel outputs.
- R11: `color_idx`, `half_flag`, `raw_pix` and `ham_active` change only at the clock edge after the plane inputs are sampled. A mode write applies to planes sampled from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Mode register write strobe |
| ctl_wdata | input | 11 | Mode register write data |
| ext_we | input | 1 | Extended register write strobe |
| ext_wdata | input | 5 | Extended register write data |
| planes | input | 8 | Plane bits of the current pixel, bit n = plane n |
| pal_rgb | input | 12 | Palette color returned for `color_idx` |
| color_idx | output | 8 | Color-table index |
| half_flag | output | 1 | Half-intensity request for this index |
| raw_pix | output | 8 | Bypass pixel value |
| ham_active | output | 1 | Hold-and-modify mode in force |
| rgb_out | output | 12 | Final color, halved when requested |
| ext_eff | output | 5 | Extended control bits as they take effect |
| mode_lace | output | 1 | Interlace control bit |
| mode_lpen | output | 1 | Light pen control bit |
| mode_ersy | output | 1 | External resync control bit |

## Verification
The bench sweeps every plane count from 0 to 9 and also 15, crossed with all dual, hold-and-modify and bypass settings. Each of these combinations gets random plane data with every bit able to be set, so bits above the count show whether masking works and counts past 8 show clamping. Plane patterns with only odd-numbered or only even-numbered planes set, and with both playfields set, separate the two priority branches of dual playfield. Count-6 runs with plane 5 forced on and forced off isolate the half-intensity path from the index path. Separate write orders of the extended register and its enable show that the value is stored while gated.

// File: rtl/bpl_decode_pkg.sv
// Package: shared mode type for the bitplane decoder.
// Assumes the plane count field is four bits wide whatever the plane number.
package bpl_decode_pkg;

    localparam int CNT_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;   // live plane count, already clamped
        logic             dual;  // playfield split by odd/even plane
        logic             ham;   // hold-and-modify selected
        logic             byp;   // color table skipped
    } mode_t;

endpackage

// File: rtl/bpl_ctl_regs.sv
// Module: mode and extended control registers.
// Holds the mode word and the extended bits, clamps the plane count to
// NPL and gates the extended bits with the enable. Assumes NPL <= 15.
module bpl_ctl_regs
    import bpl_decode_pkg::*;
#(
    parameter int NPL   = 8,
    parameter int CTL_W = 11,
    parameter int EXT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ext_we,
    input  logic [EXT_W-1:0] ext_wdata,
    output mode_t            mode,
    output logic [EXT_W-1:0] ext_eff,
    output logic             mode_lace,
    output logic             mode_lpen,
    output logic             mode_ersy
);
    localparam int B_DUAL = CNT_W;
    localparam int B_HAM  = CNT_W + 1;
    localparam int B_BYP  = CNT_W + 2;
    localparam int B_XEN  = CNT_W + 3;
    localparam int B_LACE = CNT_W + 4;
    localparam int B_LPEN = CNT_W + 5;
    localparam int B_ERSY = CNT_W + 6;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NPL);

    logic [CTL_W-1:0] ctl_q;
    logic [EXT_W-1:0] ext_q;
    logic [CNT_W-1:0] cnt_raw;

    // Purpose: hold the mode word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_wdata;
    end

    // Purpose: hold the extended bits, writable regardless of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ext_q <= '0;
        else if (ext_we) ext_q <= ext_wdata;
    end

    // Purpose: decode fields, clamp the count and gate the extended bits.
    always_comb begin
        cnt_raw   = ctl_q[CNT_W-1:0];
        mode.cnt  = (cnt_raw > CNT_MAX) ? CNT_MAX : cnt_raw;
        mode.dual = ctl_q[B_DUAL];
        mode.ham  = ctl_q[B_HAM];
        mode.byp  = ctl_q[B_BYP];
        ext_eff   = ctl_q[B_XEN] ? ext_q : '0;
        mode_lace = ctl_q[B_LACE];
        mode_lpen = ctl_q[B_LPEN];
        mode_ersy = ctl_q[B_ERSY];
    end

    // R9: a write to the extended register is always stored.
    p_ext_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_we |=> (ext_q == $past(ext_wdata)));

    // R10: reset leaves the power-up-cleared bits low.
    p_rst_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (!mode_lace && !mode_lpen && !mode_ersy && ext_eff == '0));

endmodule

// File: rtl/bpl_plane_decode.sv
// Module: combinational plane-to-index decoder.
// Masks planes above the live count, splits playfields, detects the
// half-brite case and routes the result to the index or raw path.
// Assumes NPL is even and the index is wide enough for two playfields.
module bpl_plane_decode
    import bpl_decode_pkg::*;
#(
    parameter int NPL   = 8,
    parameter int IDX_W = 8
) (
    input  mode_t            mode,
    input  logic [NPL-1:0]   planes,
    output logic [IDX_W-1:0] idx,
    output logic             half,
    output logic [IDX_W-1:0] raw
);
    localparam int PF_W   = NPL / 2;
    localparam int PF_OFS = 1 << (PF_W - 1);
    localparam int EHB_N  = 6;
    localparam int EHB_IW = EHB_N - 1;

    logic [NPL-1:0]   msk;
    logic [PF_W-1:0]  pf_a;
    logic [PF_W-1:0]  pf_b;
    logic [IDX_W-1:0] resolved;
    logic             ehb;

    // Masking: one gate per plane, enabled when the plane is below the count.
    for (genvar g = 0; g < NPL; g++) begin : g_mask
        assign msk[g] = planes[g] & (32'(mode.cnt) > g);
    end

    // Playfield split: even-numbered inputs to A, odd-numbered inputs to B.
    for (genvar g = 0; g < PF_W; g++) begin : g_split
        assign pf_a[g] = msk[2*g];
        assign pf_b[g] = msk[2*g+1];
    end

    assign ehb = (32'(mode.cnt) == EHB_N) && !mode.ham && !mode.dual;

    // Purpose: resolve playfield priority or pass the masked planes.
    always_comb begin
        if (mode.dual) begin
            if (pf_a != '0)      resolved = IDX_W'(pf_a);
            else if (pf_b != '0) resolved = IDX_W'(pf_b) + IDX_W'(PF_OFS);
            else                 resolved = '0;
        end else begin
            resolved = IDX_W'(msk);
        end
    end

    // Purpose: pick the bypass, half-brite or plain index output.
    always_comb begin
        idx  = '0;
        half = 1'b0;
        raw  = '0;
        if (mode.byp) begin
            raw = resolved;
        end else if (ehb) begin
            idx  = IDX_W'(msk[EHB_IW-1:0]);
            half = msk[EHB_IW];
        end else begin
            idx = resolved;
        end
    end

    // R2: no output bit at or above the count in single playfield.
    always_comb begin
        if (!mode.dual)
            p_mask_r2: assert (((idx | raw) >> mode.cnt) == '0);
    end

endmodule

// File: rtl/bpl_pix_pipe.sv
// Module: output pipeline.
// Stage 1 registers the decoded index; stage 2 registers the palette
// answer, halving each channel when stage 1 requested it. Assumes the
// palette answers the stage-1 index within the same cycle.
module bpl_pix_pipe #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 4,
    parameter int NCH   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    idx_d,
    input  logic                half_d,
    input  logic [IDX_W-1:0]    raw_d,
    input  logic                ham_d,
    input  logic [NCH*CH_W-1:0] pal_rgb,
    output logic [IDX_W-1:0]    idx_q,
    output logic                half_q,
    output logic [IDX_W-1:0]    raw_q,
    output logic                ham_q,
    output logic [NCH*CH_W-1:0] rgb_q
);
    logic [NCH*CH_W-1:0] rgb_d;

    // Purpose: stage-1 register of the decoded pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            half_q <= 1'b0;
            raw_q  <= '0;
            ham_q  <= 1'b0;
        end else begin
            idx_q  <= idx_d;
            half_q <= half_d;
            raw_q  <= raw_d;
            ham_q  <= ham_d;
        end
    end

    // Halving: one shifter per color channel.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign rgb_d[c*CH_W +: CH_W] = half_q
            ? {1'b0, pal_rgb[c*CH_W+1 +: CH_W-1]}
            : pal_rgb[c*CH_W +: CH_W];

        // R5: a halved channel never has its top bit set.
        p_half_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
            half_q |=> (rgb_q[c*CH_W+CH_W-1] == 1'b0));
    end

    // Purpose: stage-2 register of the final color.
    always_ff @(posedge clk) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end

    // R5: unhalved colors pass the palette answer unchanged one cycle later.
    p_rgb_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !half_q |=> (rgb_q == $past(pal_rgb)));

    // R7: a raw value excludes the index and the half flag.
    p_byp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q != '0) |-> (idx_q == '0 && !half_q));

endmodule

// File: rtl/bpl_pixel_decode.sv
// Module: top of the bitplane pixel decoder.
// Connects the control registers, the plane decoder and the output
// pipeline. Assumes an external palette answers color_idx combinationally.
module bpl_pixel_decode
    import bpl_decode_pkg::*;
#(
    parameter int NPL   = 8,
    parameter int IDX_W = 8,
    parameter int CH_W  = 4,
    parameter int NCH   = 3,
    parameter int CTL_W = 11,
    parameter int EXT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                ext_we,
    input  logic [EXT_W-1:0]    ext_wdata,
    input  logic [NPL-1:0]      planes,
    input  logic [NCH*CH_W-1:0] pal_rgb,
    output logic [IDX_W-1:0]    color_idx,
    output logic                half_flag,
    output logic [IDX_W-1:0]    raw_pix,
    output logic                ham_active,
    output logic [NCH*CH_W-1:0] rgb_out,
    output logic [EXT_W-1:0]    ext_eff,
    output logic                mode_lace,
    output logic                mode_lpen,
    output logic                mode_ersy
);
    mode_t            mode;
    logic [IDX_W-1:0] idx_d;
    logic             half_d;
    logic [IDX_W-1:0] raw_d;

    bpl_ctl_regs #(.NPL(NPL), .CTL_W(CTL_W), .EXT_W(EXT_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ext_we    (ext_we),
        .ext_wdata (ext_wdata),
        .mode      (mode),
        .ext_eff   (ext_eff),
        .mode_lace (mode_lace),
        .mode_lpen (mode_lpen),
        .mode_ersy (mode_ersy)
    );

    bpl_plane_decode #(.NPL(NPL), .IDX_W(IDX_W)) u_dec (
        .mode   (mode),
        .planes (planes),
        .idx    (idx_d),
        .half   (half_d),
        .raw    (raw_d)
    );

    bpl_pix_pipe #(.IDX_W(IDX_W), .CH_W(CH_W), .NCH(NCH)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_d   (idx_d),
        .half_d  (half_d),
        .raw_d   (raw_d),
        .ham_d   (mode.ham),
        .pal_rgb (pal_rgb),
        .idx_q   (color_idx),
        .half_q  (half_flag),
        .raw_q   (raw_pix),
        .ham_q   (ham_active),
        .rgb_q   (rgb_out)
    );

    // R4: the half flag only accompanies indices of five bits.
    p_half_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_flag |-> (color_idx[IDX_W-1:5] == '0));

endmodule

// File: tb/bpl_pixel_decode_tb.sv
module bpl_pixel_decode_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [10:0] ctl_wdata = '0;
    logic        ext_we = 1'b0;
    logic [4:0]  ext_wdata = '0;
    logic [7:0]  planes = '0;
    logic [11:0] pal_rgb;
    logic [7:0]  color_idx, raw_pix;
    logic        half_flag, ham_active, mode_lace, mode_lpen, mode_ersy;
    logic [11:0] rgb_out;
    logic [4:0]  ext_eff;
    int ncmp = 0;
    int nfail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [11:0] pal_of(input logic [7:0] i);
        return {i[3:0] ^ 4'hA, i[7:4] ^ 4'h3, i[3:0] + 4'h7};
    endfunction

    assign pal_rgb = pal_of(color_idx);

    bpl_pixel_decode u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ext_we(ext_we), .ext_wdata(ext_wdata), .planes(planes),
        .pal_rgb(pal_rgb), .color_idx(color_idx), .half_flag(half_flag),
        .raw_pix(raw_pix), .ham_active(ham_active), .rgb_out(rgb_out),
        .ext_eff(ext_eff), .mode_lace(mode_lace), .mode_lpen(mode_lpen),
        .mode_ersy(mode_ersy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [10:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_ext(input logic [4:0] v);
        @(negedge clk); ext_we = 1'b1; ext_wdata = v;
        @(negedge clk); ext_we = 1'b0;
    endtask

    // Reference model computed from R2, R3, R4, R6, R7.
    task automatic model(input int cnt, input bit d, input bit h, input bit b,
                         input logic [7:0] pl, output logic [7:0] ei,
                         output logic [7:0] er, output logic eh);
        int c = (cnt > 8) ? 8 : cnt;
        logic [7:0] m = pl & 8'((1 << c) - 1);
        logic [3:0] a = {m[6], m[4], m[2], m[0]};
        logic [3:0] bb = {m[7], m[5], m[3], m[1]};
        logic [7:0] res;
        if (d) res = (a != 0) ? {4'd0, a} : (bb != 0) ? {4'd0, bb} + 8'd8 : 8'd0;
        else   res = m;
        ei = '0; er = '0; eh = 1'b0;
        if (b) er = res;
        else if (c == 6 && !h && !d) begin ei = {3'd0, m[4:0]}; eh = m[5]; end
        else ei = res;
    endtask

    task automatic pixel(input int cnt, input bit d, input bit h, input bit b,
                         input logic [7:0] pl);
        logic [7:0] ei, er; logic eh; logic [11:0] p, er_rgb;
        model(cnt, d, h, b, pl, ei, er, eh);
        @(negedge clk); planes = pl;
        @(negedge clk);
        chk("R6 idx", color_idx, ei);
        chk("R7 raw", raw_pix, er);
        chk("R4 half", half_flag, eh);
        chk("R8 ham", ham_active, h);
        p = pal_of(ei);
        er_rgb = eh ? {1'b0, p[11:9], 1'b0, p[7:5], 1'b0, p[3:1]} : p;
        @(negedge clk);
        chk("R5 rgb", rgb_out, er_rgb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        chk("R10 idx reset", color_idx, 0);
        chk("R10 rgb reset", rgb_out, 0);
        chk("R10 ext reset", ext_eff, 0);
        chk("R1 lace reset", {mode_lace, mode_lpen, mode_ersy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count zero after reset", color_idx, 0);

        // Main sweep: R1 clamp, R2 mask, R3 condition, R6, R7, R8.
        for (int cnt = 0; cnt <= 15; cnt++) begin
            if (cnt > 9 && cnt != 15) continue;
            for (int mv = 0; mv < 8; mv++) begin
                bit d = mv[0], h = mv[1], b = mv[2];
                wr_ctl({4'b0, b, h, d, 4'(cnt)});
                for (int k = 0; k < 6; k++) pixel(cnt, d, h, b, 8'($urandom));
                pixel(cnt, d, h, b, 8'hFF);
                pixel(cnt, d, h, b, 8'hAA);
                pixel(cnt, d, h, b, 8'h55);
            end
        end

        // R3/R4: count 6 half-brite with plane 5 forced on and off.
        wr_ctl(11'h006);
        pixel(6, 0, 0, 0, 8'h3F);
        pixel(6, 0, 0, 0, 8'h1F);
        pixel(6, 0, 0, 0, 8'hE5);
        chk("R3 half set", half_flag, 1);
        wr_ctl(11'h026);
        pixel(6, 0, 1, 0, 8'h3F);
        chk("R3 ham blocks half", half_flag, 0);

        // R11: output holds until the clock edge after sampling.
        wr_ctl(11'h008);
        @(negedge clk); planes = 8'h11;
        @(negedge clk); prev = color_idx;
        planes = 8'h22; #1;
        chk("R11 no early change", color_idx, prev);
        @(negedge clk);
        chk("R11 change after edge", color_idx, 8'h22);

        // R9: extended bits stored while gated, visible once enabled.
        wr_ext(5'h1B);
        chk("R9 gated", ext_eff, 0);
        wr_ctl(11'h080);
        chk("R9 enabled", ext_eff, 5'h1B);
        wr_ext(5'h04);
        chk("R9 write while enabled", ext_eff, 5'h04);
        wr_ctl(11'h000);
        chk("R9 disabled again", ext_eff, 0);

        // R10: power-up bits set, then cleared by reset.
        wr_ctl(11'h700);
        chk("R1 lace/lpen/ersy set", {mode_lace, mode_lpen, mode_ersy}, 3'b111);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R10 cleared", {mode_lace, mode_lpen, mode_ersy}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    end
endmodule